// File: doc/BRIEF.md
# Serial Transmitter Sharing a Port Pin

This block turns bytes into asynchronous-style serial frames on a pin that also serves as a general-purpose port bit. While the transmit enable is high the block owns the pin: it drives it, idles it at the mark level (1) and sends frames. While the enable is low the pin belongs to the port. Its level follows the port data bit and its driver follows the port direction bit. Software sends a line break by writing 0 to the port data bit and then dropping the enable. Dropping the enable also kills any frame in progress on the spot.

Software writes a byte into a one-entry holding register, which clears the empty flag. The transmitter moves the byte into its shift register as soon as it is free. That transfer sets the empty flag again, so a second byte can wait behind the frame in flight and follows it with no gap. Bit timing comes from a base-clock enable, and each bit lasts a fixed number of those ticks. A mode input selects synchronous operation. In that mode any receive error flag that is set holds off the start of a new frame.

Top module: `tx_pin_share`

## Requirements
- R1: After reset the empty flag is 1 and no frame is in progress, so with the enable high the pin idles at 1.
- R2: While the transmit enable is 0, the pin level equals the port data bit and the pin output enable equals the port direction bit, within the same cycle. A port data bit of 0 therefore gives a continuous break.
- R3: While the enable is 1 and no frame is in progress, the output enable is 1 and the pin is 1.
- R4: A frame is a 0 start bit, then 8 data bits with bit 0 first, then a 1 stop bit. Each bit lasts 16 base-clock ticks, and the bit level holds while no tick arrives.
- R5: A write clears the empty flag on the next cycle. The flag sets again on the cycle the byte moves into the shift register, which happens only while the enable is 1.
- R6: A byte that is waiting when a stop bit ends starts its start bit on the very next cycle, with no idle time between frames.
- R7: Lowering the enable aborts a frame at once. After re-enabling, the pin idles at 1 and the aborted frame does not resume.
- R8: In synchronous mode (mode input 1) no frame starts while the overrun, parity or framing error input is 1. The pending byte stays pending and is sent once all three are 0.
- R9: In asynchronous mode (mode input 0) the error inputs have no effect on transmission.
- R10: A write during a frame leaves the frame's bits unchanged.
- R11: A pending byte and the empty flag are kept while the enable is 0, and the byte is sent after the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Base-clock enable, 16 per bit |
| txEn | input | 1 | Transmit enable |
| wrStb | input | 1 | Write strobe for the holding register |
| wrData | input | 8 | Byte to transmit |
| dataEmpty | output | 1 | Holding register is free |
| portData | input | 1 | Port data bit used while disabled |
| portDir | input | 1 | Port direction bit (1 = drive) |
| errOverrun | input | 1 | Receive overrun flag |
| errParity | input | 1 | Receive parity flag |
| errFraming | input | 1 | Receive framing flag |
| syncMode | input | 1 | 1 = synchronous mode |
| pinOut | output | 1 | Pin level |
| pinOe | output | 1 | Pin output enable |

## Verification
The hardest cases to reach from the ports sit on the exact cycle where a stop bit ends. Here a pending byte must start with no gap, an abort must win over a restart, and an error flag must hold off a reload. The bench reaches these cases with directed sequences. It writes a second byte right after the first is loaded, drops the enable in the middle of a frame, and holds a parity error in synchronous mode across a frame boundary. A long random run then layers sparse ticks, random writes, random enable drops and random error flags on top of this. A bench model that works from the frame definition predicts the pin and flag on every cycle.

// File: rtl/tx_pin_pkg.sv
package tx_pin_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // move holding register into shifter
    logic shift;   // advance to next frame bit
    logic active;  // frame in progress
  } txStrobe_t;
endpackage

// File: rtl/tx_pin_ctrl.sv
module tx_pin_ctrl
  import tx_pin_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       txEn,
  input  logic       dataEmpty,
  input  logic [2:0] errFlags,
  input  logic       syncMode,
  output txStrobe_t  strobe
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int TICK_W  = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_W - 1);

  logic              busy;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic              blocked, bitEnd, frameEnd, startNow;

  always_comb begin
    blocked  = syncMode && (|errFlags);
    bitEnd   = busy && tick && (tickCnt == TICK_LAST);
    frameEnd = bitEnd && (bitIdx == BIT_LAST);
    startNow = txEn && !dataEmpty && !blocked && (!busy || frameEnd);
    strobe.load   = startNow;
    strobe.shift  = bitEnd && !frameEnd;
    strobe.active = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !txEn) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (startNow) begin
      busy    <= 1'b1;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (frameEnd) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (busy && tick) begin
      if (tickCnt == TICK_LAST) begin
        tickCnt <= '0;
        bitIdx  <= bitIdx + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_pin_dp.sv
module tx_pin_dp
  import tx_pin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  txStrobe_t         strobe,
  input  logic              txEn,
  input  logic              portData,
  input  logic              portDir,
  output logic              dataEmpty,
  output logic              pinOut,
  output logic              pinOe
);
  localparam int FRAME_W = DATA_W + 2;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg   <= '0;
      dataEmpty <= 1'b1;
    end else if (wrStb) begin
      holdReg   <= wrData;
      dataEmpty <= 1'b0;
    end else if (strobe.load) begin
      dataEmpty <= 1'b1;
    end
  end

  // stop bit, data, start bit; bit 0 goes out first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.load) begin
      shiftReg <= {1'b1, holdReg, 1'b0};
    end else if (strobe.shift) begin
      shiftReg <= {1'b1, shiftReg[FRAME_W-1:1]};
    end
  end

  always_comb begin
    if (txEn) begin
      pinOe  = 1'b1;
      pinOut = strobe.active ? shiftReg[0] : 1'b1;
    end else begin
      pinOe  = portDir;
      pinOut = portData;
    end
  end
endmodule

// File: rtl/tx_pin_share.sv
module tx_pin_share
  import tx_pin_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              txEn,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  output logic              dataEmpty,
  input  logic              portData,
  input  logic              portDir,
  input  logic              errOverrun,
  input  logic              errParity,
  input  logic              errFraming,
  input  logic              syncMode,
  output logic              pinOut,
  output logic              pinOe
);
  txStrobe_t strobe;

  tx_pin_ctrl #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .txEn(txEn), .dataEmpty(dataEmpty),
    .errFlags({errOverrun, errParity, errFraming}), .syncMode(syncMode),
    .strobe(strobe)
  );

  tx_pin_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .strobe(strobe),
    .txEn(txEn), .portData(portData), .portDir(portDir),
    .dataEmpty(dataEmpty), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/tx_pin_chk.sv
module tx_pin_chk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic txEn,
  input logic wrStb,
  input logic dataEmpty,
  input logic anyErr,
  input logic syncMode,
  input logic busy,
  input logic pinOut,
  input logic pinOe
);
  // R7
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> !busy);
  // R8
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && anyErr) |=> !$rose(dataEmpty));
  // R5
  write_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !dataEmpty);
  // R5
  load_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEmpty) |-> $past(txEn));
  // R3
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && !busy) |-> (pinOut && pinOe));
  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && busy && !tick) |=> (!txEn || $stable(pinOut)));
  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txEn && $rose(busy)) |-> !pinOut);
endmodule

bind tx_pin_share tx_pin_chk i_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .txEn(txEn), .wrStb(wrStb),
  .dataEmpty(dataEmpty), .anyErr(errOverrun | errParity | errFraming),
  .syncMode(syncMode), .busy(strobe.active), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/test_tx_pin_share.sv
module test_tx_pin_share;
  localparam int TPB     = 16;
  localparam int FRAME_T = 10 * TPB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1, txEn = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic portData = 1'b1, portDir = 1'b0;
  logic errOverrun = 1'b0, errParity = 1'b0, errFraming = 1'b0, syncMode = 1'b0;
  logic dataEmpty, pinOut, pinOe;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string phaseTag = "";

  always #2.5 clk = ~clk;

  tx_pin_share i_tx_pin_share (
    .clk(clk), .rstN(rstN), .tick(tick), .txEn(txEn), .wrStb(wrStb),
    .wrData(wrData), .dataEmpty(dataEmpty), .portData(portData),
    .portDir(portDir), .errOverrun(errOverrun), .errParity(errParity),
    .errFraming(errFraming), .syncMode(syncMode), .pinOut(pinOut), .pinOe(pinOe)
  );

  // reference model built from the frame definition
  logic       mEmpty = 1'b1, mBusy = 1'b0;
  logic [7:0] mHold = '0;
  logic [9:0] mFrame = '1;
  int         mTicks = 0;

  always @(posedge clk) begin
    logic done, go;
    done = mBusy && tick && (mTicks == FRAME_T - 1);
    go   = txEn && !mEmpty && !(syncMode && (errOverrun || errParity || errFraming))
           && (!mBusy || done);
    if (!rstN) begin
      mEmpty <= 1'b1; mBusy <= 1'b0; mTicks <= 0; mHold <= '0;
    end else begin
      if (!txEn) begin mBusy <= 1'b0; mTicks <= 0; end
      else if (go) begin mBusy <= 1'b1; mTicks <= 0; mFrame <= {1'b1, mHold, 1'b0}; end
      else if (done) begin mBusy <= 1'b0; mTicks <= 0; end
      else if (mBusy && tick) mTicks <= mTicks + 1;
      if (wrStb) begin mHold <= wrData; mEmpty <= 1'b0; end
      else if (go) mEmpty <= 1'b1;
    end
  end

  function automatic logic expPin();
    if (!txEn) return portData;
    if (mBusy) return mFrame[mTicks / TPB];
    return 1'b1;
  endfunction

  function automatic logic expOe();
    return txEn ? 1'b1 : portDir;
  endfunction

  task automatic checkNow(string tag);
    string t;
    t = tag;
    if (t == "") t = !txEn ? "R2" : (mBusy ? "R4" : "R3");
    checks++;
    if (pinOut !== expPin() || pinOe !== expOe()) begin
      errors++;
      $display("FAIL %s pin actual %b/%b expected %b/%b at %0t", t, pinOut, pinOe,
               expPin(), expOe(), $time);
    end
    checks++;
    if (dataEmpty !== mEmpty) begin
      errors++;
      $display("FAIL %s empty actual %b expected %b at %0t", (tag == "") ? "R5" : tag,
               dataEmpty, mEmpty, $time);
    end
  endtask

  task automatic cyc(int n, bit randTick = 1'b0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      checkNow(phaseTag);
      tick = randTick ? 1'($urandom % 2) : 1'b1;
    end
  endtask

  task automatic writeByte(logic [7:0] d);
    wrData = d; wrStb = 1'b1;
    cyc(1);
    wrStb = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state, port released
    phaseTag = "R1"; checkNow("R1");
    txEn = 1'b1; #1; checkNow("R1");
    cyc(3);

    // R4 / R5: single frame
    phaseTag = "R4"; writeByte(8'hA5); cyc(FRAME_T + 5);

    // R6: back-to-back frames, R10: write during a frame
    phaseTag = "R6"; writeByte(8'h3C); cyc(3); writeByte(8'hC3);
    phaseTag = "R10"; cyc(40); writeByte(8'h81); cyc(60);
    phaseTag = "R6"; cyc(2 * FRAME_T + 20);

    // R7: abort mid-frame into break, then re-enable
    writeByte(8'h0F); cyc(50);
    phaseTag = "R7"; portData = 1'b0; portDir = 1'b1; txEn = 1'b0; #1; checkNow("R7");
    phaseTag = "R2"; cyc(40);
    portDir = 1'b0; cyc(5);
    phaseTag = "R7"; txEn = 1'b1; #1; checkNow("R7"); cyc(20);

    // R11: pending byte kept while disabled
    phaseTag = "R11"; txEn = 1'b0; portData = 1'b1; cyc(2); writeByte(8'h5A); cyc(30);
    txEn = 1'b1; cyc(FRAME_T + 5);

    // R8: sync mode blocked by each error flag
    phaseTag = "R8"; syncMode = 1'b1; errParity = 1'b1; writeByte(8'h96); cyc(200);
    errParity = 1'b0; errOverrun = 1'b1; cyc(20);
    errOverrun = 1'b0; errFraming = 1'b1; cyc(20);
    errFraming = 1'b0; cyc(FRAME_T + 5);

    // R9: async mode ignores error flags
    phaseTag = "R9"; syncMode = 1'b0; errOverrun = 1'b1; errParity = 1'b1; errFraming = 1'b1;
    writeByte(8'hE7); cyc(FRAME_T + 5);
    errOverrun = 1'b0; errParity = 1'b0; errFraming = 1'b0;

    // random mix
    phaseTag = "";
    for (int k = 0; k < 6000; k++) begin
      wrStb = ($urandom % 40) == 0;
      wrData = 8'($urandom);
      if (($urandom % 300) == 0) txEn = ~txEn;
      syncMode = ($urandom % 3) == 0;
      errOverrun = ($urandom % 20) == 0;
      errParity = ($urandom % 20) == 0;
      errFraming = ($urandom % 20) == 0;
      portData = 1'($urandom);
      portDir = 1'($urandom);
      cyc(1, 1'b1);
    end
    wrStb = 1'b0;

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule